// File: doc/BRIEF.md
# Multimode 16-bit Reload Timer

A 16-bit down-counter with a 16-bit reload latch, controlled by an 8-bit mode register and reached through a byte-wide register port. It runs in one of four modes. Periodic timer mode counts prescaled or alternate-source ticks. Pulse output mode toggles an output pin at each underflow. Event counter mode counts edges on an external pin. Pulse-width measurement mode counts ticks only while the pin sits at a chosen level. Every underflow sets a sticky timer request flag. A second sticky flag records the pin edge that polarity selects.

Sixteen-bit values cross the 8-bit port coherently because the bytes go in a fixed order. A write stages the low byte and commits both bytes together when the high byte is written. A read of the high byte freezes the low byte of the running count for the read that follows. The register port uses plain single-cycle strobes: `bus_wr` and `bus_rd` act in the cycle they are high, and no transfer is ever stalled, so the port has no back-pressure. `bus_rdata` is combinational from `bus_addr` while `bus_rd` is high. `alt_tick` is a one-cycle enable pulse from an external count-source generator.

Top module: `mm_reload_timer`

## Requirements
- R1: A write to address 0 (count low) only stages the byte; the count and the reload latch keep their values.
- R2: A write to address 1 (count high) loads the reload latch with {written byte, staged low byte}. When mode bit 0 is 0, the counter takes the same value on that clock edge.
- R3: When mode bit 0 is 1, a high-byte write updates only the latch. The counter takes the new latch value at its next underflow.
- R4: A read of address 1 returns the live high byte and captures the live low byte. Every read of address 0 returns the captured byte until the next read of address 1.
- R5: With mode bit 3 = 0, ticks come from a free-running prescaler. Bits 2:1 select the ratio: 00 gives 8, 01 gives 16, 10 gives 32 and 11 gives 64 clocks. With bit 3 = 1, each `alt_tick` pulse is one tick.
- R6: Mode bits 5:4 select the mode: 00 periodic timer, 01 pulse output, 10 event counter, 11 pulse-width measurement. Address 2 reads back the mode register.
- R7: While mode bit 7 is 1, the counter does not count in any mode. Clearing the bit resumes counting.
- R8: On a tick at count 0 the counter reloads from the latch and the timer flag (flags bit 0) is set; otherwise a tick decrements the count. After reset the mode register, count, latch and flags are all 0.
- R9: Writing the mode register sets `pulse_out` to the inverse of bit 6. In pulse output mode, `pulse_out` toggles at every underflow; in other modes it holds its level.
- R10: In event counter mode, each rising edge of the synchronized pin is one tick when bit 6 is 0, and each falling edge is one tick when bit 6 is 1.
- R11: In pulse-width mode, source ticks count only while the synchronized pin is high (bit 6 = 0) or low (bit 6 = 1). The end of that level sets the pin flag.
- R12: `ext_pin` passes through two synchronizing flip-flops. In every mode, the pin flag (flags bit 1) is set on a falling edge when bit 6 is 0 and on a rising edge when bit 6 is 1.
- R13: The flags at address 3 are sticky. Writing 1 to a flag bit clears it, writing 0 leaves it unchanged, and a set in the same cycle wins. `irq_tmr` and `irq_pin` mirror the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register select: 0 count low, 1 count high, 2 mode, 3 flags |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational while bus_rd is high |
| alt_tick | input | 1 | Alternate count-source enable pulse |
| ext_pin | input | 1 | Asynchronous external pin |
| pulse_out | output | 1 | Pulse output level |
| irq_tmr | output | 1 | Timer underflow request flag |
| irq_pin | output | 1 | Pin edge request flag |

## Verification
A register write or a tick takes effect on the clock edge that samples it. The bench drives each strobe or `alt_tick` pulse for exactly one cycle from a falling edge and reads the result on the following falling edge. A change on `ext_pin` reaches the count and the pin flag on the third rising edge after the change, so the bench waits four cycles after every pin move before it checks. Prescaler ratios are checked as the spacing in cycles between steady-state `pulse_out` toggles, which equals the reload value plus one, times the ratio. This measurement does not depend on the free-running prescaler's phase.

// File: rtl/mrt_pkg.sv
package mrt_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int ADDR_W = 2;
  localparam int FLAG_N = 2;

  localparam logic [ADDR_W-1:0] A_CNT_LO = 2'd0;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 2'd1;
  localparam logic [ADDR_W-1:0] A_MODE   = 2'd2;
  localparam logic [ADDR_W-1:0] A_FLAGS  = 2'd3;

  localparam int F_TMR = 0;
  localparam int F_PIN = 1;

  typedef enum logic [1:0] {
    MD_TIMER = 2'b00,
    MD_PULSE = 2'b01,
    MD_EVENT = 2'b10,
    MD_WIDTH = 2'b11
  } mode_e;

  // bit 7 .. bit 0
  typedef struct packed {
    logic       stop;
    logic       pol;
    mode_e      md;
    logic       alt;
    logic [1:0] div;
    logic       latch_only;
  } mode_t;
endpackage

// File: rtl/mrt_prescaler.sv
module mrt_prescaler #(
  parameter int MIN_LOG2 = 3,
  parameter int SEL_W    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] div_sel,
  output logic             tick
);
  localparam int NRAT = 1 << SEL_W;
  localparam int PW   = MIN_LOG2 + NRAT - 1;

  logic [PW-1:0]   pcnt;
  logic [NRAT-1:0] term;

  always_ff @(posedge clk) begin
    if (!rst_n) pcnt <= '0;
    else        pcnt <= pcnt + 1'b1;
  end

  for (genvar i = 0; i < NRAT; i++) begin : g_term
    assign term[i] = &pcnt[MIN_LOG2+i-1:0];
  end

  assign tick = term[div_sel];

  AST_PRE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n) tick |=> (pcnt[MIN_LOG2-1:0] == '0)); // R5
endmodule

// File: rtl/mrt_pin_sync.sv
module mrt_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sq;
  logic              prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sq   <= '0;
      prev <= 1'b0;
    end else begin
      sq   <= {sq[STAGES-2:0], pin};
      prev <= sq[STAGES-1];
    end
  end

  assign level = sq[STAGES-1];
  assign rise  = level & ~prev;
  assign fall  = ~level & prev;

  AST_SYNC_RISE: assert property (@(posedge clk) disable iff (!rst_n) rise |=> prev); // R12
endmodule

// File: rtl/mrt_regif.sv
module mrt_regif
  import mrt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [FLAG_N-1:0] flags,
  output logic [BYTE_W-1:0] rdata,
  output mode_t             mode_q,
  output logic              mode_wr,
  output mode_t             mode_wval,
  output logic              latch_wr,
  output logic [CNT_W-1:0]  latch_val,
  output logic [FLAG_N-1:0] flag_clr
);
  logic [BYTE_W-1:0] stage_lo;
  logic [BYTE_W-1:0] snap_lo;
  logic              rd_hi;

  assign mode_wr   = wr && (addr == A_MODE);
  assign mode_wval = mode_t'(wdata);
  assign latch_wr  = wr && (addr == A_CNT_HI);
  assign latch_val = {wdata, stage_lo};
  assign flag_clr  = (wr && (addr == A_FLAGS)) ? wdata[FLAG_N-1:0] : '0;
  assign rd_hi     = rd && (addr == A_CNT_HI);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_lo <= '0;
      snap_lo  <= '0;
      mode_q   <= '0;
    end else begin
      if (wr && (addr == A_CNT_LO)) stage_lo <= wdata;
      if (mode_wr)                  mode_q   <= mode_wval;
      if (rd_hi)                    snap_lo  <= cnt[BYTE_W-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    if (rd) begin
      case (addr)
        A_CNT_LO: rdata = snap_lo;
        A_CNT_HI: rdata = cnt[CNT_W-1:BYTE_W];
        A_MODE:   rdata = mode_q;
        default:  rdata = {{(BYTE_W-FLAG_N){1'b0}}, flags};
      endcase
    end
  end

  AST_SNAP_TAKE: assert property (@(posedge clk) disable iff (!rst_n) rd_hi |=> (snap_lo == $past(cnt[BYTE_W-1:0]))); // R4
  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !rd_hi |=> $stable(snap_lo)); // R4
endmodule

// File: rtl/mrt_counter.sv
module mrt_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         latch_wr,
  input  logic         load_now,
  input  logic [W-1:0] latch_val,
  input  logic         pulse_mode,
  input  logic         mode_wr,
  input  logic         start_level,
  output logic [W-1:0] cnt,
  output logic         underflow,
  output logic         pulse_out
);
  logic [W-1:0] latch_q;

  assign underflow = tick && !load_now && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q   <= '0;
      cnt       <= '0;
      pulse_out <= 1'b1;
    end else begin
      if (latch_wr) latch_q <= latch_val;
      if (load_now)       cnt <= latch_val;
      else if (underflow) cnt <= latch_q;
      else if (tick)      cnt <= cnt - 1'b1;
      if (mode_wr)                      pulse_out <= start_level;
      else if (underflow && pulse_mode) pulse_out <= ~pulse_out;
    end
  end

  AST_LOAD_NOW:   assert property (@(posedge clk) disable iff (!rst_n) load_now |=> (cnt == $past(latch_val))); // R2
  AST_LATCH_ONLY: assert property (@(posedge clk) disable iff (!rst_n) (latch_wr && !load_now && !tick) |=> $stable(cnt)); // R3
  AST_RELOAD:     assert property (@(posedge clk) disable iff (!rst_n) underflow |=> (cnt == $past(latch_q))); // R8
  AST_DECREMENT:  assert property (@(posedge clk) disable iff (!rst_n) (tick && !load_now && cnt != '0) |=> (cnt == $past(cnt) - 1'b1)); // R8
  AST_PULSE_FLIP: assert property (@(posedge clk) disable iff (!rst_n) (underflow && pulse_mode && !mode_wr) |=> (pulse_out != $past(pulse_out))); // R9
  AST_PULSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!pulse_mode && !mode_wr) |=> $stable(pulse_out)); // R9
endmodule

// File: rtl/mm_reload_timer.sv
module mm_reload_timer
  import mrt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              alt_tick,
  input  logic              ext_pin,
  output logic              pulse_out,
  output logic              irq_tmr,
  output logic              irq_pin
);
  mode_t              mode_q, mode_wval;
  logic               mode_wr, latch_wr, load_now;
  logic [CNT_W-1:0]   latch_val, cnt;
  logic [FLAG_N-1:0]  flag_clr, flags;
  logic               pre_tick, src_tick, cnt_tick, underflow;
  logic               pin_lvl, pin_rise, pin_fall, pin_evt;

  mrt_regif u_regif (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .wdata(bus_wdata), .cnt(cnt), .flags(flags), .rdata(bus_rdata),
    .mode_q(mode_q), .mode_wr(mode_wr), .mode_wval(mode_wval),
    .latch_wr(latch_wr), .latch_val(latch_val), .flag_clr(flag_clr)
  );

  mrt_prescaler #(.MIN_LOG2(3), .SEL_W(2)) u_pre (
    .clk(clk), .rst_n(rst_n), .div_sel(mode_q.div), .tick(pre_tick)
  );

  mrt_pin_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(ext_pin),
    .level(pin_lvl), .rise(pin_rise), .fall(pin_fall)
  );

  assign src_tick = mode_q.alt ? alt_tick : pre_tick;
  assign pin_evt  = mode_q.pol ? pin_rise : pin_fall;
  assign load_now = latch_wr && !mode_q.latch_only;

  always_comb begin
    case (mode_q.md)
      MD_EVENT: cnt_tick = mode_q.pol ? pin_fall : pin_rise;
      MD_WIDTH: cnt_tick = src_tick && (pin_lvl != mode_q.pol);
      default:  cnt_tick = src_tick;
    endcase
    if (mode_q.stop) cnt_tick = 1'b0;
  end

  mrt_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(cnt_tick), .latch_wr(latch_wr),
    .load_now(load_now), .latch_val(latch_val),
    .pulse_mode(mode_q.md == MD_PULSE), .mode_wr(mode_wr),
    .start_level(~mode_wval.pol), .cnt(cnt), .underflow(underflow),
    .pulse_out(pulse_out)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else begin
      flags[F_TMR] <= (flags[F_TMR] & ~flag_clr[F_TMR]) | underflow;
      flags[F_PIN] <= (flags[F_PIN] & ~flag_clr[F_PIN]) | pin_evt;
    end
  end

  assign irq_tmr = flags[F_TMR];
  assign irq_pin = flags[F_PIN];

  AST_STOP_HOLD:  assert property (@(posedge clk) disable iff (!rst_n) (mode_q.stop && !load_now) |=> $stable(cnt)); // R7
  AST_TMR_SET:    assert property (@(posedge clk) disable iff (!rst_n) underflow |=> irq_tmr); // R8
  AST_TMR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (irq_tmr && !flag_clr[F_TMR]) |=> irq_tmr); // R13
  AST_PIN_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (irq_pin && !flag_clr[F_PIN]) |=> irq_pin); // R13
  AST_PIN_SET:    assert property (@(posedge clk) disable iff (!rst_n) pin_evt |=> irq_pin); // R12
endmodule

// File: tb/test_mm_reload_timer.sv
`timescale 1ns/1ps
module test_mm_reload_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       alt_tick = 1'b0, ext_pin = 1'b0;
  logic       pulse_out, irq_tmr, irq_pin;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  mm_reload_timer i_mm_reload_timer (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .alt_tick(alt_tick), .ext_pin(ext_pin), .pulse_out(pulse_out),
    .irq_tmr(irq_tmr), .irq_pin(irq_pin)
  );

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic wr16(input logic [15:0] v);
    wr(2'd0, v[7:0]); wr(2'd1, v[15:8]);
  endtask

  task automatic rd16(output logic [15:0] v);
    logic [7:0] h, l;
    rd(2'd1, h); rd(2'd0, l); v = {h, l};
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); alt_tick = 1'b1;
      @(negedge clk); alt_tick = 1'b0;
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d; logic [15:0] v;
    rd(2'd3, d); chk("R8 reset flags", d, 0);
    rd(2'd2, d); chk("R8 reset mode", d, 0);
    rd16(v);     chk("R8 reset count", v, 0);
    chk("R9 reset pulse_out", pulse_out, 1);
    wr(2'd2, 8'h88); wr(2'd3, 8'h03);
    chk("R13 flags cleared", irq_tmr | irq_pin, 0);
  endtask

  task automatic t_write();
    logic [15:0] v; logic [7:0] d;
    wr(2'd2, 8'h08);
    rd(2'd2, d); chk("R6 mode readback", d, 8'h08);
    wr16(16'h1205); rd16(v); chk("R2 write loads count", v, 16'h1205);
    wr(2'd0, 8'h77); rd16(v); chk("R1 low write staged only", v, 16'h1205);
  endtask

  task automatic t_latch_only();
    logic [15:0] v;
    wr16(16'h0001);
    wr(2'd2, 8'h09); wr16(16'h0010);
    rd16(v); chk("R3 latch-only keeps count", v, 16'h0001);
    tick(1); rd16(v); chk("R3 count before underflow", v, 16'h0000);
    chk("R8 no flag before underflow", irq_tmr, 0);
    tick(1); rd16(v); chk("R3 new latch at underflow", v, 16'h0010);
    chk("R8 flag at underflow", irq_tmr, 1);
  endtask

  task automatic t_flags();
    logic [7:0] d;
    wr(2'd3, 8'h02); chk("R13 write 0 keeps flag", irq_tmr, 1);
    rd(2'd3, d);     chk("R13 flag readback", d, 8'h01);
    wr(2'd3, 8'h01); chk("R13 write 1 clears flag", irq_tmr, 0);
  endtask

  task automatic t_timer();
    logic [15:0] v;
    wr(2'd2, 8'h08); wr16(16'h0002);
    tick(2); rd16(v); chk("R8 decrement", v, 16'h0000);
    chk("R8 flag clear at zero", irq_tmr, 0);
    tick(1); rd16(v); chk("R8 periodic reload", v, 16'h0002);
    chk("R8 flag after reload", irq_tmr, 1);
    wr(2'd3, 8'h01);
  endtask

  task automatic t_snap();
    logic [7:0] d;
    wr16(16'h0100);
    rd(2'd1, d); chk("R4 high byte live", d, 8'h01);
    tick(1);
    rd(2'd0, d); chk("R4 low byte from snapshot", d, 8'h00);
    rd(2'd0, d); chk("R4 snapshot persists", d, 8'h00);
    rd(2'd1, d); chk("R4 new high byte", d, 8'h00);
    rd(2'd0, d); chk("R4 new snapshot", d, 8'hFF);
  endtask

  task automatic t_stop();
    logic [15:0] v;
    wr(2'd2, 8'h88); wr16(16'h0020);
    tick(3); rd16(v); chk("R7 stopped count holds", v, 16'h0020);
    wr(2'd2, 8'h08);
    tick(1); rd16(v); chk("R7 resume counting", v, 16'h001F);
  endtask

  task automatic t_pulse();
    wr(2'd2, 8'h18); chk("R9 start level high", pulse_out, 1);
    wr16(16'h0001);
    tick(2); chk("R9 toggle at underflow", pulse_out, 0);
    tick(2); chk("R9 toggle again", pulse_out, 1);
    wr(2'd2, 8'h58); chk("R9 start level low", pulse_out, 0);
    wr(2'd2, 8'h08); wr16(16'h0000);
    tick(1); chk("R6 timer mode no toggle", pulse_out, 1);
    wr(2'd3, 8'h01);
  endtask

  task automatic meas(output int per);
    logic last; int c;
    last = pulse_out; c = 0;
    while (pulse_out == last && c < 2000) begin @(negedge clk); c++; end
    last = pulse_out; c = 0;
    while (pulse_out == last && c < 2000) begin @(negedge clk); c++; end
    per = c;
  endtask

  task automatic t_presc();
    int p;
    wr(2'd2, 8'h10); wr16(16'h0003); meas(p); chk("R5 ratio 8 period", p, 32);
    wr(2'd2, 8'h12); wr16(16'h0001); meas(p); chk("R5 ratio 16 period", p, 32);
    wr(2'd2, 8'h14); wr16(16'h0000); meas(p); chk("R5 ratio 32 period", p, 32);
    wr(2'd2, 8'h16); wr16(16'h0001); meas(p); chk("R5 ratio 64 period", p, 128);
    wr(2'd2, 8'h88); wr(2'd3, 8'h03);
  endtask

  task automatic t_event();
    logic [15:0] v;
    ext_pin = 1'b0; settle();
    wr(2'd2, 8'h28); wr16(16'h0005); wr(2'd3, 8'h03);
    ext_pin = 1'b1; settle();
    rd16(v); chk("R10 rising edge counts", v, 16'h0004);
    chk("R12 no pin flag on rise pol0", irq_pin, 0);
    ext_pin = 1'b0; settle();
    rd16(v); chk("R10 falling edge ignored pol0", v, 16'h0004);
    chk("R12 pin flag on fall pol0", irq_pin, 1);
    wr(2'd3, 8'h02);
    wr(2'd2, 8'h68);
    ext_pin = 1'b1; settle();
    rd16(v); chk("R10 rising ignored pol1", v, 16'h0004);
    chk("R12 pin flag on rise pol1", irq_pin, 1);
    ext_pin = 1'b0; settle();
    rd16(v); chk("R10 falling edge counts pol1", v, 16'h0003);
  endtask

  task automatic t_width();
    logic [15:0] v;
    wr(2'd2, 8'h38); wr16(16'h000A); wr(2'd3, 8'h03);
    tick(2); rd16(v); chk("R11 no count at low level", v, 16'h000A);
    ext_pin = 1'b1; settle();
    tick(3); rd16(v); chk("R11 counts at high level", v, 16'h0007);
    chk("R11 no flag during level", irq_pin, 0);
    ext_pin = 1'b0; settle();
    chk("R11 flag at end of level", irq_pin, 1);
    tick(1); rd16(v); chk("R11 stops after level", v, 16'h0007);
    wr(2'd2, 8'h78);
    tick(1); rd16(v); chk("R11 pol1 counts low level", v, 16'h0006);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write();
    t_latch_only();
    t_flags();
    t_timer();
    t_snap();
    t_stop();
    t_pulse();
    t_presc();
    t_event();
    t_width();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule